// File: doc/BRIEF.md
# Security interrupt status aggregator

This block gathers the level interrupt lines raised by the memory protection controllers, the peripheral protection controllers and the expansion master security controllers of a secure subsystem. It folds them into three 32-bit status words, each source at a fixed and sparse bit position. Internal sources sit in the low half of a word and expansion sources sit from bit 16 upward. The register bank next to it supplies a shared write-data bus and one write strobe per control register. It reads the status and enable words straight off the block's outputs.

For each peripheral protection controller the block drives an enable line and a clear line, both taken from that controller's bit position. For the expansion master security controllers it drives a clear line and a non-secure line per controller from the upper half of the last value written. It also drives one combined interrupt, raised while any enabled master-security status bit is set. Every output comes from a register and changes one clock after the input or strobe that causes it.

Top module: `secagg_top`

## Requirements
- R1: While `rst` is high on a rising clock edge, every output is zero after that edge, whatever the inputs are.
- R2: Memory-protection status follows its inputs one clock later: internal input n at `mpc_stat_o` bit n, expansion input n at bit 16+n. All other bits read zero.
- R3: Peripheral-protection status bits are set one clock after their input is high and then stay set. The two internal APB inputs map to bits 0 and 1, APB expansion input i to bit 4+i, and AHB expansion input i to bit 20+i. All other bits of `ppc_stat_o` read zero.
- R4: A `ppc_clr_we_i` strobe clears each status bit whose `wdata_i` bit is 1, but only if that bit's input is low in the same cycle. A bit whose input is high stays set, and bits written 0 keep their value.
- R5: A `ppc_en_we_i` strobe loads `ppc_en_o` with `wdata_i` masked to the mapped positions of R3. Each controller's enable output equals its bit in `ppc_en_o`.
- R6: Each peripheral protection controller's clear output equals its bit in `ppc_stat_o`.
- R7: Master-security status follows its inputs one clock later: expansion input n at `msc_stat_o` bit 16+n. All other bits read zero.
- R8: A `msc_en_we_i` strobe loads `msc_en_o` with `wdata_i` masked to bits 16 up to 16+N_XMSC-1. `msc_irq_o` is high exactly when `msc_stat_o & msc_en_o` is nonzero, both taken as they stand after the same edge.
- R9: A `msc_clr_we_i` strobe sets `mscx_clr_o[n]` to `wdata_i[16+n]`. The value holds until the next such strobe.
- R10: A `msc_ns_we_i` strobe sets `mscx_ns_o[n]` to `wdata_i[16+n]`. The value holds until the next such strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mpc_lvl_i | input | N_MPC | Internal memory-protection interrupt levels |
| mpcx_lvl_i | input | N_XMPC | Expansion memory-protection interrupt levels |
| ppc_apb_lvl_i | input | 2 | Internal APB protection controller interrupt levels |
| ppc_apbx_lvl_i | input | N_XPPC | APB expansion protection controller interrupt levels |
| ppc_ahbx_lvl_i | input | N_XPPC | AHB expansion protection controller interrupt levels |
| mscx_lvl_i | input | N_XMSC | Expansion master-security interrupt levels |
| wdata_i | input | 32 | Write data shared by all strobes |
| ppc_en_we_i | input | 1 | Write strobe for the protection-controller enable word |
| ppc_clr_we_i | input | 1 | Write strobe for the protection-controller clear |
| msc_en_we_i | input | 1 | Write strobe for the master-security enable word |
| msc_clr_we_i | input | 1 | Write strobe for the master-security clear lines |
| msc_ns_we_i | input | 1 | Write strobe for the master-security non-secure lines |
| mpc_stat_o | output | 32 | Memory-protection status word |
| ppc_stat_o | output | 32 | Protection-controller status word |
| ppc_en_o | output | 32 | Protection-controller enable word |
| msc_stat_o | output | 32 | Master-security status word |
| msc_en_o | output | 32 | Master-security enable word |
| ppc_apb_en_o | output | 2 | Enable lines to the internal APB controllers |
| ppc_apb_clr_o | output | 2 | Clear lines to the internal APB controllers |
| ppc_apbx_en_o | output | N_XPPC | Enable lines to the APB expansion controllers |
| ppc_apbx_clr_o | output | N_XPPC | Clear lines to the APB expansion controllers |
| ppc_ahbx_en_o | output | N_XPPC | Enable lines to the AHB expansion controllers |
| ppc_ahbx_clr_o | output | N_XPPC | Clear lines to the AHB expansion controllers |
| mscx_clr_o | output | N_XMSC | Clear lines to the expansion master-security controllers |
| mscx_ns_o | output | N_XMSC | Non-secure lines to the expansion master-security controllers |
| msc_irq_o | output | 1 | Combined master-security interrupt |

## Verification
Every result of this block is due exactly one rising edge after the input level or write strobe that causes it. This holds for the status words, the sticky set and clear of R3 and R4, the enable words, the fanned-out controller lines and the combined interrupt, which is formed from next-state values. The bench changes stimulus on the falling edge and advances its behavioural model on the rising edge. It compares every output on the next falling edge, so each comparison falls in the single cycle where the result first becomes due. Directed checks place a clear strobe in the same cycle as a high source to pin down the priority of set over clear.

// File: rtl/secagg_pkg.sv
package secagg_pkg;
  localparam int WORD_W    = 32;
  localparam int XBASE     = 16;
  localparam int APB_N     = 2;
  localparam int APBX_BASE = 4;
  localparam int AHBX_BASE = 20;

  // Positions of protection-controller bits inside the status word
  function automatic logic [WORD_W-1:0] ppc_map(input int nx);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < APB_N; i++) m[i] = 1'b1;
    for (int i = 0; i < nx; i++) begin
      m[APBX_BASE+i] = 1'b1;
      m[AHBX_BASE+i] = 1'b1;
    end
    return m;
  endfunction

  // Positions of expansion bits starting at XBASE
  function automatic logic [WORD_W-1:0] xmap(input int n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < n; i++) m[XBASE+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/secagg_sticky.sv
module secagg_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  logic [W-1:0] clr_eff;

  // set has priority: a bit whose source is high cannot be cleared
  always_comb clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= set_i | (q & ~clr_eff);
  end

  assign q_o = q;
endmodule

// File: rtl/secagg_mpc.sv
module secagg_mpc
  import secagg_pkg::*;
#(
  parameter int N_MPC  = 2,
  parameter int N_XMPC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MPC-1:0]  lvl_i,
  input  logic [N_XMPC-1:0] xlvl_i,
  output logic [WORD_W-1:0] stat_o
);
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] stat_q;

  always_comb begin
    word = '0;
    word[N_MPC-1:0]      = lvl_i;
    word[XBASE +: N_XMPC] = xlvl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= word;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/secagg_ppc.sv
module secagg_ppc
  import secagg_pkg::*;
#(
  parameter int N_XPPC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [APB_N-1:0]  apb_lvl_i,
  input  logic [N_XPPC-1:0] apbx_lvl_i,
  input  logic [N_XPPC-1:0] ahbx_lvl_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              en_we_i,
  input  logic              clr_we_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] en_o,
  output logic [APB_N-1:0]  apb_en_o,
  output logic [APB_N-1:0]  apb_clr_o,
  output logic [N_XPPC-1:0] apbx_en_o,
  output logic [N_XPPC-1:0] apbx_clr_o,
  output logic [N_XPPC-1:0] ahbx_en_o,
  output logic [N_XPPC-1:0] ahbx_clr_o
);
  localparam logic [WORD_W-1:0] MAP = ppc_map(N_XPPC);

  logic [WORD_W-1:0] src;
  logic [WORD_W-1:0] en_q;

  always_comb begin
    src = '0;
    src[APB_N-1:0]           = apb_lvl_i;
    src[APBX_BASE +: N_XPPC] = apbx_lvl_i;
    src[AHBX_BASE +: N_XPPC] = ahbx_lvl_i;
  end

  secagg_sticky #(.W(WORD_W)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .set_i    (src),
    .clr_we_i (clr_we_i),
    .clr_i    (wdata_i & MAP),
    .q_o      (stat_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (en_we_i) en_q <= wdata_i & MAP;
  end

  assign en_o = en_q;

  // fan the word bits back out to each controller
  genvar g;
  generate
    for (g = 0; g < APB_N; g++) begin : g_apb
      assign apb_en_o[g]  = en_q[g];
      assign apb_clr_o[g] = stat_o[g];
    end
    for (g = 0; g < N_XPPC; g++) begin : g_exp
      assign apbx_en_o[g]  = en_q[APBX_BASE+g];
      assign apbx_clr_o[g] = stat_o[APBX_BASE+g];
      assign ahbx_en_o[g]  = en_q[AHBX_BASE+g];
      assign ahbx_clr_o[g] = stat_o[AHBX_BASE+g];
    end
  endgenerate
endmodule

// File: rtl/secagg_msc.sv
module secagg_msc
  import secagg_pkg::*;
#(
  parameter int N_XMSC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_XMSC-1:0] xlvl_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              en_we_i,
  input  logic              clr_we_i,
  input  logic              ns_we_i,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] en_o,
  output logic [N_XMSC-1:0] clr_o,
  output logic [N_XMSC-1:0] ns_o,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] MAP = xmap(N_XMSC);

  logic [WORD_W-1:0] stat_d, stat_q;
  logic [WORD_W-1:0] en_d, en_q;
  logic [N_XMSC-1:0] clr_q, ns_q;
  logic              irq_q;

  always_comb begin
    stat_d = '0;
    stat_d[XBASE +: N_XMSC] = xlvl_i;
    en_d = en_we_i ? (wdata_i & MAP) : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
      clr_q  <= '0;
      ns_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      en_q   <= en_d;
      irq_q  <= |(stat_d & en_d);
      if (clr_we_i) clr_q <= wdata_i[XBASE +: N_XMSC];
      if (ns_we_i)  ns_q  <= wdata_i[XBASE +: N_XMSC];
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign clr_o  = clr_q;
  assign ns_o   = ns_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/secagg_top.sv
module secagg_top
  import secagg_pkg::*;
#(
  parameter int N_MPC  = 2,
  parameter int N_XMPC = 4,
  parameter int N_XPPC = 4,
  parameter int N_XMSC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MPC-1:0]  mpc_lvl_i,
  input  logic [N_XMPC-1:0] mpcx_lvl_i,
  input  logic [1:0]        ppc_apb_lvl_i,
  input  logic [N_XPPC-1:0] ppc_apbx_lvl_i,
  input  logic [N_XPPC-1:0] ppc_ahbx_lvl_i,
  input  logic [N_XMSC-1:0] mscx_lvl_i,
  input  logic [31:0]       wdata_i,
  input  logic              ppc_en_we_i,
  input  logic              ppc_clr_we_i,
  input  logic              msc_en_we_i,
  input  logic              msc_clr_we_i,
  input  logic              msc_ns_we_i,
  output logic [31:0]       mpc_stat_o,
  output logic [31:0]       ppc_stat_o,
  output logic [31:0]       ppc_en_o,
  output logic [31:0]       msc_stat_o,
  output logic [31:0]       msc_en_o,
  output logic [1:0]        ppc_apb_en_o,
  output logic [1:0]        ppc_apb_clr_o,
  output logic [N_XPPC-1:0] ppc_apbx_en_o,
  output logic [N_XPPC-1:0] ppc_apbx_clr_o,
  output logic [N_XPPC-1:0] ppc_ahbx_en_o,
  output logic [N_XPPC-1:0] ppc_ahbx_clr_o,
  output logic [N_XMSC-1:0] mscx_clr_o,
  output logic [N_XMSC-1:0] mscx_ns_o,
  output logic              msc_irq_o
);
  secagg_mpc #(.N_MPC(N_MPC), .N_XMPC(N_XMPC)) u_mpc (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (mpc_lvl_i),
    .xlvl_i (mpcx_lvl_i),
    .stat_o (mpc_stat_o)
  );

  secagg_ppc #(.N_XPPC(N_XPPC)) u_ppc (
    .clk        (clk),
    .rst        (rst),
    .apb_lvl_i  (ppc_apb_lvl_i),
    .apbx_lvl_i (ppc_apbx_lvl_i),
    .ahbx_lvl_i (ppc_ahbx_lvl_i),
    .wdata_i    (wdata_i),
    .en_we_i    (ppc_en_we_i),
    .clr_we_i   (ppc_clr_we_i),
    .stat_o     (ppc_stat_o),
    .en_o       (ppc_en_o),
    .apb_en_o   (ppc_apb_en_o),
    .apb_clr_o  (ppc_apb_clr_o),
    .apbx_en_o  (ppc_apbx_en_o),
    .apbx_clr_o (ppc_apbx_clr_o),
    .ahbx_en_o  (ppc_ahbx_en_o),
    .ahbx_clr_o (ppc_ahbx_clr_o)
  );

  secagg_msc #(.N_XMSC(N_XMSC)) u_msc (
    .clk      (clk),
    .rst      (rst),
    .xlvl_i   (mscx_lvl_i),
    .wdata_i  (wdata_i),
    .en_we_i  (msc_en_we_i),
    .clr_we_i (msc_clr_we_i),
    .ns_we_i  (msc_ns_we_i),
    .stat_o   (msc_stat_o),
    .en_o     (msc_en_o),
    .clr_o    (mscx_clr_o),
    .ns_o     (mscx_ns_o),
    .irq_o    (msc_irq_o)
  );
endmodule

// File: rtl/secagg_chk.sv
module secagg_chk
  import secagg_pkg::*;
#(
  parameter int N_MPC  = 2,
  parameter int N_XMPC = 4,
  parameter int N_XPPC = 4,
  parameter int N_XMSC = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [N_MPC-1:0]  mpc_lvl_i,
  input logic [N_XMPC-1:0] mpcx_lvl_i,
  input logic [31:0]       mpc_stat_o,
  input logic [1:0]        ppc_apb_lvl_i,
  input logic              ppc_clr_we_i,
  input logic [31:0]       ppc_stat_o,
  input logic [31:0]       msc_stat_o,
  input logic [31:0]       msc_en_o,
  input logic              msc_irq_o,
  input logic              msc_clr_we_i,
  input logic [N_XMSC-1:0] mscx_clr_o
);
  localparam logic [31:0] PMAP = ppc_map(N_XPPC);

  a_r2_mpc_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mpc_stat_o[N_MPC-1:0] == $past(mpc_lvl_i)) &&
             (mpc_stat_o[XBASE +: N_XMPC] == $past(mpcx_lvl_i)));

  a_r3_set_apb: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ppc_stat_o[1:0] & $past(ppc_apb_lvl_i)) == $past(ppc_apb_lvl_i)));

  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (ppc_stat_o & ~PMAP) == 32'h0);

  a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
    !ppc_clr_we_i |=> ((ppc_stat_o & $past(ppc_stat_o)) == $past(ppc_stat_o)));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    msc_irq_o == ((msc_stat_o & msc_en_o) != 32'h0));

  a_r9_clear_hold: assert property (@(posedge clk) disable iff (rst)
    !msc_clr_we_i |=> $stable(mscx_clr_o));
endmodule

bind secagg_top secagg_chk #(
  .N_MPC(N_MPC), .N_XMPC(N_XMPC), .N_XPPC(N_XPPC), .N_XMSC(N_XMSC)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mpc_lvl_i     (mpc_lvl_i),
  .mpcx_lvl_i    (mpcx_lvl_i),
  .mpc_stat_o    (mpc_stat_o),
  .ppc_apb_lvl_i (ppc_apb_lvl_i),
  .ppc_clr_we_i  (ppc_clr_we_i),
  .ppc_stat_o    (ppc_stat_o),
  .msc_stat_o    (msc_stat_o),
  .msc_en_o      (msc_en_o),
  .msc_irq_o     (msc_irq_o),
  .msc_clr_we_i  (msc_clr_we_i),
  .mscx_clr_o    (mscx_clr_o)
);

// File: tb/sim_secagg_top.sv
`timescale 1ns/1ps
module sim_secagg_top;
  localparam int NM = 2, NXM = 4, NXP = 4, NXS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NM-1:0]  mpc_lvl = '0;
  logic [NXM-1:0] mpcx_lvl = '0;
  logic [1:0]     apb_lvl = '0;
  logic [NXP-1:0] apbx_lvl = '0, ahbx_lvl = '0;
  logic [NXS-1:0] mscx_lvl = '0;
  logic [31:0]    wdata = '0;
  logic pen_we = 0, pclr_we = 0, men_we = 0, mclr_we = 0, mns_we = 0;

  logic [31:0] mpc_stat, ppc_stat, ppc_en, msc_stat, msc_en;
  logic [1:0]  apb_en, apb_clr;
  logic [NXP-1:0] apbx_en, apbx_clr, ahbx_en, ahbx_clr;
  logic [NXS-1:0] mscx_clr, mscx_ns;
  logic msc_irq;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference model state
  bit [31:0] m_mpc, m_ppc, m_pen, m_msc, m_men;
  bit        m_irq;
  bit [NXS-1:0] m_mclr, m_mns;

  always #2.5 clk = ~clk;

  secagg_top #(.N_MPC(NM), .N_XMPC(NXM), .N_XPPC(NXP), .N_XMSC(NXS)) u0 (
    .clk(clk), .rst(rst),
    .mpc_lvl_i(mpc_lvl), .mpcx_lvl_i(mpcx_lvl),
    .ppc_apb_lvl_i(apb_lvl), .ppc_apbx_lvl_i(apbx_lvl), .ppc_ahbx_lvl_i(ahbx_lvl),
    .mscx_lvl_i(mscx_lvl), .wdata_i(wdata),
    .ppc_en_we_i(pen_we), .ppc_clr_we_i(pclr_we),
    .msc_en_we_i(men_we), .msc_clr_we_i(mclr_we), .msc_ns_we_i(mns_we),
    .mpc_stat_o(mpc_stat), .ppc_stat_o(ppc_stat), .ppc_en_o(ppc_en),
    .msc_stat_o(msc_stat), .msc_en_o(msc_en),
    .ppc_apb_en_o(apb_en), .ppc_apb_clr_o(apb_clr),
    .ppc_apbx_en_o(apbx_en), .ppc_apbx_clr_o(apbx_clr),
    .ppc_ahbx_en_o(ahbx_en), .ppc_ahbx_clr_o(ahbx_clr),
    .mscx_clr_o(mscx_clr), .mscx_ns_o(mscx_ns), .msc_irq_o(msc_irq)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // model advances on the rising edge from the inputs held since the falling edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_mpc = 0; m_ppc = 0; m_pen = 0; m_msc = 0; m_men = 0;
      m_irq = 0; m_mclr = 0; m_mns = 0;
    end else begin
      bit [31:0] src, valid;
      m_mpc = 0;
      for (int n = 0; n < NM; n++)  m_mpc[n] = mpc_lvl[n];
      for (int n = 0; n < NXM; n++) m_mpc[16+n] = mpcx_lvl[n];
      src = 0; valid = 0;
      for (int n = 0; n < 2; n++) begin src[n] = apb_lvl[n]; valid[n] = 1; end
      for (int n = 0; n < NXP; n++) begin
        src[4+n] = apbx_lvl[n];  valid[4+n] = 1;
        src[20+n] = ahbx_lvl[n]; valid[20+n] = 1;
      end
      if (pclr_we) m_ppc = m_ppc & ~(wdata & valid);
      m_ppc = m_ppc | src;
      if (pen_we) m_pen = wdata & valid;
      m_msc = 0;
      for (int n = 0; n < NXS; n++) m_msc[16+n] = mscx_lvl[n];
      if (men_we) begin
        m_men = 0;
        for (int n = 0; n < NXS; n++) m_men[16+n] = wdata[16+n];
      end
      m_irq = (m_msc & m_men) != 0;
      if (mclr_we) for (int n = 0; n < NXS; n++) m_mclr[n] = wdata[16+n];
      if (mns_we)  for (int n = 0; n < NXS; n++) m_mns[n]  = wdata[16+n];
    end
  end

  // compare every output on the falling edge
  always @(negedge clk) begin
    if (!finished) begin
      bit [31:0] e_apbx_en, e_apbx_clr, e_ahbx_en, e_ahbx_clr;
      e_apbx_en = 0; e_apbx_clr = 0; e_ahbx_en = 0; e_ahbx_clr = 0;
      for (int n = 0; n < NXP; n++) begin
        e_apbx_en[n] = m_pen[4+n];  e_apbx_clr[n] = m_ppc[4+n];
        e_ahbx_en[n] = m_pen[20+n]; e_ahbx_clr[n] = m_ppc[20+n];
      end
      cmp("R2 mpc_stat", mpc_stat, m_mpc);
      cmp("R3/R4 ppc_stat", ppc_stat, m_ppc);
      cmp("R5 ppc_en", ppc_en, m_pen);
      cmp("R5 apb_en", {30'b0, apb_en}, {30'b0, m_pen[1:0]});
      cmp("R5 apbx_en", {28'b0, apbx_en}, e_apbx_en);
      cmp("R5 ahbx_en", {28'b0, ahbx_en}, e_ahbx_en);
      cmp("R6 apb_clr", {30'b0, apb_clr}, {30'b0, m_ppc[1:0]});
      cmp("R6 apbx_clr", {28'b0, apbx_clr}, e_apbx_clr);
      cmp("R6 ahbx_clr", {28'b0, ahbx_clr}, e_ahbx_clr);
      cmp("R7 msc_stat", msc_stat, m_msc);
      cmp("R8 msc_en", msc_en, m_men);
      cmp("R8 msc_irq", {31'b0, msc_irq}, {31'b0, m_irq});
      cmp("R9 mscx_clr", {28'b0, mscx_clr}, {28'b0, m_mclr});
      cmp("R10 mscx_ns", {28'b0, mscx_ns}, {28'b0, m_mns});
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic strobes_off();
    pen_we = 0; pclr_we = 0; men_we = 0; mclr_we = 0; mns_we = 0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with every input active
    @(negedge clk);
    mpc_lvl = '1; mpcx_lvl = '1; apb_lvl = '1; apbx_lvl = '1; ahbx_lvl = '1;
    mscx_lvl = '1; wdata = '1;
    pen_we = 1; pclr_we = 1; men_we = 1; mclr_we = 1; mns_we = 1;
    repeat (3) step();
    cmp("R1 reset ppc_stat", ppc_stat, 32'h0);
    cmp("R1 reset msc_irq", {31'b0, msc_irq}, 32'h0);
    mpc_lvl = '0; mpcx_lvl = '0; apb_lvl = '0; apbx_lvl = '0; ahbx_lvl = '0;
    mscx_lvl = '0; wdata = '0; strobes_off();
    rst = 0;
    repeat (2) step();

    // R3: one-cycle pulses at sparse positions, then sticky
    apb_lvl = 2'b01; apbx_lvl = 4'b0010; ahbx_lvl = 4'b1000;
    step();
    apb_lvl = 0; apbx_lvl = 0; ahbx_lvl = 0;
    step();
    cmp("R3 sparse sticky", ppc_stat, 32'h0080_0021);

    // R5: enable masked to mapped bits
    wdata = 32'hFFFF_FFFF; pen_we = 1;
    step(); strobes_off();
    cmp("R5 enable mask", ppc_en, 32'h00F0_00F3);

    // R4: clear while source high has no effect on that bit
    apb_lvl = 2'b01; step();
    wdata = 32'hFFFF_FFFF; pclr_we = 1;
    step(); strobes_off();
    cmp("R4 clear blocked by high source", ppc_stat, 32'h0000_0001);
    apb_lvl = 0; wdata = 32'h0000_0001; pclr_we = 1;
    step(); strobes_off();
    cmp("R4 clear after source low", ppc_stat, 32'h0);

    // R2: memory-protection mirror
    mpc_lvl = 2'b10; mpcx_lvl = 4'b0101;
    step();
    cmp("R2 mpc positions", mpc_stat, 32'h0005_0002);
    mpc_lvl = 0; mpcx_lvl = 0;
    step();

    // R7/R8: master-security status and combined interrupt
    mscx_lvl = 4'b0101; wdata = 32'h000F_FFFF; men_we = 1;
    step(); strobes_off();
    cmp("R7 msc_stat", msc_stat, 32'h0005_0000);
    cmp("R8 irq with overlap", {31'b0, msc_irq}, 32'h1);
    wdata = 32'h000A_0000; men_we = 1;
    step(); strobes_off();
    cmp("R8 irq without overlap", {31'b0, msc_irq}, 32'h0);
    mscx_lvl = 4'b1000;
    step();
    cmp("R8 irq on status change", {31'b0, msc_irq}, 32'h1);
    mscx_lvl = 0;

    // R9/R10: clear and non-secure lines from the upper half
    wdata = 32'h0003_FFFF; mclr_we = 1;
    step(); strobes_off();
    wdata = 32'h000C_0000; mns_we = 1;
    step(); strobes_off();
    cmp("R9 clear lines", {28'b0, mscx_clr}, 32'h3);
    cmp("R10 ns lines", {28'b0, mscx_ns}, 32'hC);

    // mixed traffic, compared cycle by cycle against the model
    for (int k = 0; k < 800; k++) begin
      mpc_lvl  = NM'($urandom);
      mpcx_lvl = NXM'($urandom);
      apb_lvl  = 2'($urandom) & 2'($urandom);
      apbx_lvl = NXP'($urandom) & NXP'($urandom);
      ahbx_lvl = NXP'($urandom) & NXP'($urandom);
      mscx_lvl = NXS'($urandom);
      wdata    = $urandom;
      pen_we   = ($urandom % 6) == 0;
      pclr_we  = ($urandom % 3) == 0;
      men_we   = ($urandom % 6) == 0;
      mclr_we  = ($urandom % 5) == 0;
      mns_we   = ($urandom % 5) == 0;
      step();
    end
    strobes_off();
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule